// File: doc/BRIEF.md
# Byte-Register I2C Master with One-Behind Receive

This block is a bus master for a two-wire serial bus, driven by software through six byte-wide registers. Software opens a transfer by setting a master bit in the control register, ends it by clearing that bit, and can re-open the bus mid-transfer with a repeated-start bit. Bytes are moved through a single data register. In transmit direction, a write to that register sends the byte. In receive direction, a read of that register hands back the byte that the previous receive cycle captured, and starts the next receive cycle on the bus. Received data therefore always runs one byte behind the register reads. Software primes the pipe with one throw-away read after addressing a device. It must set the no-acknowledge bit before the read that launches the final byte.

The clock line and the data line are driven as open-drain pull-down enables, and each line is sampled back on its own input. A status register reports whether a byte is in flight, a byte-done pending flag, the acknowledge bit the target returned, and a bus-busy flag. The bus-busy flag is tracked from START and STOP conditions seen on the wires. The pending flag is set only by byte transfers, never by START or STOP, so software has to poll bus-busy for those. A level interrupt follows the pending flag while interrupts are enabled.

Top module: `i2c_pipe_master`

## Requirements
- R1: Register byte offsets are: own address 0x00, clock divider 0x04, control 0x08, status 0x0C, data 0x10, filter setting 0x14. Own address and filter setting are plain read/write storage. After reset, control, divider and data read 0x00, status reads 0x80, both line enables are 0 and irq is 0.
- R2: Each clock-line period lasts 4×(divider+1) system clocks, and the line is released for 2×(divider+1) of them.
- R3: Control bit 7 enables the block. While enabled and not yet master, writing control bit 5 from 0 to 1 produces a START: the data line falls while the clock line is high. Status bit 5 (bus busy) then reads 1, and status bit 1 (pending) stays 0.
- R4: When control bit 4 is 1 (transmit), a data-register write sends that byte, most significant bit first. Status bit 7 reads 0 while the byte is in flight. After the 9th clock, status bit 7 and status bit 1 read 1, and status bit 0 holds the sampled acknowledge bit (1 = not acknowledged).
- R5: When control bit 4 is 0 (receive) and the block is master, a data-register read returns the byte captured by the previous receive cycle and launches the next receive byte. A data read while not master launches nothing.
- R6: In the 9th clock of a received byte the master drives the data line low (ACK) when control bit 3 is 0, and leaves it released (NACK) when control bit 3 is 1.
- R7: Writing control bit 5 from 1 to 0 while master produces a STOP: the data line rises while the clock line is high. Bus busy then reads 0, and the pending flag is not set.
- R8: Writing control with bits 5 and 2 both set, while already master, produces a repeated START and keeps bus busy at 1. Control bit 2 always reads back 0.
- R9: irq is 1 exactly while status bit 1 and control bit 6 are both 1. A status write with bit 1 = 0 clears the pending flag, and a status write with bit 1 = 1 leaves it set.
- R10: Clearing control bit 7 releases both lines within one clock, returns the bit engine to idle, and clears the pending and acknowledge flags. Bus busy keeps its value.
- R11: The data line changes while the clock line is high only to form START, repeated START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (side effect on data register only) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt: pending flag and interrupt enable |
| scl_in | input | 1 | Sampled clock line level |
| sda_in | input | 1 | Sampled data line level |
| scl_oe | output | 1 | Clock line pull-down enable (1 pulls low) |
| sda_oe | output | 1 | Data line pull-down enable (1 pulls low) |

## Verification
Suppose the receive byte register or the pipeline hand-off goes wrong. The next data read then returns the wrong byte immediately, one byte-time after the cycle that captured it. A phase or bit counter that is off shows up within one clock-line period, either as a data-line edge while the clock is high or as a clock high time that differs from 2×(divider+1) cycles. It also shifts the byte the target model collects. Flag state is seen on the very next status read or on irq: a missed acknowledge sample, a pending flag raised by START or STOP, or a busy flag not following the bus conditions.

// File: rtl/i2c_pipe_pkg.sv
`timescale 1ns/1ps
package i2c_pipe_pkg;
  localparam int BYTE_W = 8;

  localparam logic [4:0] OFS_OWN = 5'h00;
  localparam logic [4:0] OFS_DIV = 5'h04;
  localparam logic [4:0] OFS_CTL = 5'h08;
  localparam logic [4:0] OFS_STA = 5'h0C;
  localparam logic [4:0] OFS_DAT = 5'h10;
  localparam logic [4:0] OFS_FLT = 5'h14;

  localparam int CB_EN  = 7;
  localparam int CB_IEN = 6;
  localparam int CB_MST = 5;
  localparam int CB_TX  = 4;
  localparam int CB_NAK = 3;
  localparam int CB_RS  = 2;

  localparam int SB_PEND = 1;
  localparam logic [7:0] CTL_KEEP = 8'hF9;

  typedef enum logic [2:0] {CMD_NONE, CMD_START, CMD_STOP, CMD_RSTART, CMD_BYTE} cmd_e;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_HOLD, ST_BIT, ST_STOP, ST_RSTART} eng_st_e;
endpackage

// File: rtl/i2c_pipe_tick.sv
`timescale 1ns/1ps
module i2c_pipe_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q >= div);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_pipe_engine.sv
`timescale 1ns/1ps
module i2c_pipe_engine
  import i2c_pipe_pkg::*;
#(
  parameter int NBITS = BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  cmd_e             cmd,
  input  logic [NBITS-1:0] tx_byte,
  input  logic             tx_mode,
  input  logic             nack,
  input  logic             sda_in,
  output logic             take,
  output logic             byte_done,
  output logic [NBITS-1:0] rx_byte,
  output logic             ack_n,
  output logic             was_tx,
  output logic             in_byte,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int BIT_W = $clog2(NBITS + 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(NBITS);

  eng_st_e          st_q, st_d;
  logic [1:0]       ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [NBITS-1:0] sh_q, sh_d;
  logic             tx_q, tx_d, nak_q, nak_d, ackn_q, ackn_d;
  logic             scl_q, scl_d, sda_q, sda_d, done_q, done_d;
  logic             last;

  assign last = (bit_q == LAST);
  assign take = !clr && (((cmd == CMD_START) && (st_q == ST_IDLE)) ||
                         ((cmd inside {CMD_STOP, CMD_RSTART, CMD_BYTE}) && (st_q == ST_HOLD)));

  always_comb begin
    st_d = st_q; ph_d = ph_q; bit_d = bit_q; sh_d = sh_q;
    tx_d = tx_q; nak_d = nak_q; ackn_d = ackn_q;
    scl_d = scl_q; sda_d = sda_q; done_d = 1'b0;
    if (clr) begin
      st_d = ST_IDLE; ph_d = '0; bit_d = '0; scl_d = 1'b0; sda_d = 1'b0;
    end else if (take) begin
      ph_d = '0;
      case (cmd)
        CMD_START:  st_d = ST_START;
        CMD_STOP:   st_d = ST_STOP;
        CMD_RSTART: st_d = ST_RSTART;
        default: begin
          st_d = ST_BIT; bit_d = '0; sh_d = tx_byte; tx_d = tx_mode; nak_d = nack;
        end
      endcase
    end else if (tick) begin
      ph_d = ph_q + 2'd1;
      case (st_q)
        ST_START:
          if (ph_q == 2'd0) sda_d = 1'b1;
          else begin scl_d = 1'b1; st_d = ST_HOLD; end
        ST_BIT:
          case (ph_q)
            2'd0: sda_d = last ? (!tx_q && !nak_q) : (tx_q && !sh_q[NBITS-1]);
            2'd1: scl_d = 1'b0;
            2'd2: if (last) ackn_d = sda_in;
                  else      sh_d = {sh_q[NBITS-2:0], sda_in};
            default: begin
              scl_d = 1'b1;
              if (last) begin st_d = ST_HOLD; done_d = 1'b1; end
              else bit_d = bit_q + BIT_W'(1);
            end
          endcase
        ST_STOP:
          case (ph_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            default: begin sda_d = 1'b0; st_d = ST_IDLE; end
          endcase
        ST_RSTART:
          case (ph_q)
            2'd0: sda_d = 1'b0;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b1;
            default: begin scl_d = 1'b1; st_d = ST_HOLD; end
          endcase
        default: ph_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= '0; bit_q <= '0; sh_q <= '0;
      tx_q <= 1'b0; nak_q <= 1'b0; ackn_q <= 1'b0;
      scl_q <= 1'b0; sda_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bit_q <= bit_d; sh_q <= sh_d;
      tx_q <= tx_d; nak_q <= nak_d; ackn_q <= ackn_d;
      scl_q <= scl_d; sda_q <= sda_d; done_q <= done_d;
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = sh_q;
  assign ack_n     = ackn_q;
  assign was_tx    = tx_q;
  assign in_byte   = (st_q == ST_BIT);
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;

  // R11: data edge under a released clock only while forming START/STOP
  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && $past(!scl_q) && (sda_q != $past(sda_q)) && !$past(clr))
      |-> ($past(st_q) inside {ST_START, ST_STOP, ST_RSTART}));

  // R2: the clock line only moves on a quarter-period tick
  assert_scl_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_q != $past(scl_q)) && !$past(clr)) |-> $past(tick));
endmodule

// File: rtl/i2c_pipe_master.sv
`timescale 1ns/1ps
module i2c_pipe_master
  import i2c_pipe_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  logic rs_meta, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs_meta <= 1'b0; rs_q <= 1'b0; end
    else        begin rs_meta <= 1'b1; rs_q <= rs_meta; end
  end

  logic [7:0]       own_q, own_d, flt_q, flt_d, ctl_q, ctl_d, dat_q, dat_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             mif_q, mif_d, rxak_q, rxak_d, busy_q, busy_d;
  logic             scl_p, sda_p;
  cmd_e             pend_q, pend_d;

  logic             en, tick, take, done, ackn, was_tx, in_byte;
  logic [BYTE_W-1:0] rx_byte;
  logic             wr_ctl, wr_dat, wr_sta, rd_dat;

  assign en     = ctl_q[CB_EN];
  assign wr_ctl = reg_wr && (reg_addr == OFS_CTL);
  assign wr_dat = reg_wr && (reg_addr == OFS_DAT);
  assign wr_sta = reg_wr && (reg_addr == OFS_STA);
  assign rd_dat = reg_rd && (reg_addr == OFS_DAT);

  i2c_pipe_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rs_q), .run(en), .div(div_q), .tick(tick));

  i2c_pipe_engine #(.NBITS(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rs_q), .clr(!en), .tick(tick), .cmd(pend_q),
    .tx_byte(dat_q), .tx_mode(ctl_q[CB_TX]), .nack(ctl_q[CB_NAK]), .sda_in(sda_in),
    .take(take), .byte_done(done), .rx_byte(rx_byte), .ack_n(ackn), .was_tx(was_tx),
    .in_byte(in_byte), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always_comb begin
    own_d = own_q; flt_d = flt_q; ctl_d = ctl_q; dat_d = dat_q; div_d = div_q;
    mif_d = mif_q; rxak_d = rxak_q; busy_d = busy_q; pend_d = pend_q;
    if (take) pend_d = CMD_NONE;
    if (!en) begin mif_d = 1'b0; rxak_d = 1'b0; pend_d = CMD_NONE; end
    if (reg_wr && (reg_addr == OFS_OWN)) own_d = reg_wdata;
    if (reg_wr && (reg_addr == OFS_FLT)) flt_d = reg_wdata;
    if (reg_wr && (reg_addr == OFS_DIV)) div_d = reg_wdata[DIV_W-1:0];
    if (wr_sta && !reg_wdata[SB_PEND]) mif_d = 1'b0;
    if (wr_ctl) begin
      ctl_d = reg_wdata & CTL_KEEP;
      if (reg_wdata[CB_EN] && reg_wdata[CB_MST] && !ctl_q[CB_MST]) pend_d = CMD_START;
      else if (en && ctl_q[CB_MST] && !reg_wdata[CB_MST])          pend_d = CMD_STOP;
      else if (en && ctl_q[CB_MST] && reg_wdata[CB_RS])            pend_d = CMD_RSTART;
    end
    if (wr_dat) begin
      dat_d = reg_wdata;
      if (en && ctl_q[CB_MST] && ctl_q[CB_TX]) pend_d = CMD_BYTE;
    end
    if (rd_dat && en && ctl_q[CB_MST] && !ctl_q[CB_TX]) pend_d = CMD_BYTE;
    if (done && en) begin
      mif_d = 1'b1;
      if (was_tx) rxak_d = ackn;
      else        dat_d  = rx_byte;
    end
    if (scl_in && scl_p) begin
      if (sda_p && !sda_in)      busy_d = 1'b1;
      else if (!sda_p && sda_in) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      own_q <= '0; flt_q <= '0; ctl_q <= '0; dat_q <= '0; div_q <= '0;
      mif_q <= 1'b0; rxak_q <= 1'b0; busy_q <= 1'b0; pend_q <= CMD_NONE;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      own_q <= own_d; flt_q <= flt_d; ctl_q <= ctl_d; dat_q <= dat_d; div_q <= div_d;
      mif_q <= mif_d; rxak_q <= rxak_d; busy_q <= busy_d; pend_q <= pend_d;
      scl_p <= scl_in; sda_p <= sda_in;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_OWN: reg_rdata = own_q;
      OFS_DIV: reg_rdata = 8'(div_q);
      OFS_CTL: reg_rdata = ctl_q;
      OFS_STA: reg_rdata = {!(in_byte || (pend_q == CMD_BYTE)), 1'b0, busy_q, 3'b000, mif_q, rxak_q};
      OFS_DAT: reg_rdata = dat_q;
      OFS_FLT: reg_rdata = flt_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = mif_q && ctl_q[CB_IEN];

  // R4 / R7: the pending flag only rises after a finished byte, never after START/STOP
  assert_pend_after_byte_R4: assert property (@(posedge clk) disable iff (!rs_q)
    $rose(mif_q) |-> $past(done));

  // R9: the pending flag only falls on a status write of 0 or on disable
  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rs_q)
    $fell(mif_q) |-> ($past(wr_sta && !reg_wdata[SB_PEND]) || $past(!en)));

  // R3: bus busy rises only after this master pulled the data line
  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rs_q)
    $rose(busy_q) |-> $past(sda_oe));

  // R10: disabling releases both lines on the next edge
  assert_disable_release_R10: assert property (@(posedge clk) disable iff (!rs_q)
    !en |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_pipe_master_bench.sv
`timescale 1ns/1ps
module i2c_pipe_master_bench;
  localparam logic [4:0] A_OWN = 5'h00, A_DIV = 5'h04, A_CTL = 5'h08,
                         A_STA = 5'h0C, A_DAT = 5'h10, A_FLT = 5'h14;
  localparam logic [6:0] SL_ADDR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe, scl_line, sda_line;
  logic sl_pull = 1'b0;

  always #4 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | sl_pull);

  i2c_pipe_master u_i2c_pipe_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  int checks = 0, errs = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic poll(input logic [7:0] mask, input logic [7:0] val, input string tag);
    logic [7:0] v;
    int n = 0;
    do begin rd(A_STA, v); n++; end while (((v & mask) != val) && n < 3000);
    check(tag, int'(v & mask), int'(val));
  endtask

  // ---- behavioural target on the bus ----
  logic [7:0] rd_mem [3] = '{8'hC3, 8'h5E, 8'h96};
  int start_cnt = 0, stop_cnt = 0, sl_mode = 0, sl_cnt = 0, sl_idx = 0;
  bit sl_rise = 0, sl_rw = 0, sl_mnak = 0;
  logic [7:0] sl_sh = '0, sl_cur = '0, sl_last = '0;
  bit ack_log [$];
  event sl_byte_ev;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    start_cnt++; sl_mode = 1; sl_cnt = 0; sl_rise = 0; sl_pull = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    stop_cnt++; sl_mode = 0; sl_pull = 1'b0;
  end
  always @(posedge scl_line) begin
    sl_rise = 1;
    if (sl_mode != 0) begin
      if (sl_cnt < 8 && sl_mode != 3) sl_sh = {sl_sh[6:0], sda_line};
      if (sl_cnt == 8 && sl_mode == 3) begin sl_mnak = sda_line; ack_log.push_back(sda_line); end
    end
  end
  always @(negedge scl_line) if (sl_mode != 0 && sl_rise) begin
    sl_rise = 0; sl_cnt++;
    if (sl_cnt == 8) begin
      if (sl_mode == 1) begin
        if (sl_sh[7:1] == SL_ADDR) begin sl_pull = 1'b1; sl_rw = sl_sh[0]; end
        else begin sl_mode = 0; sl_pull = 1'b0; end
      end else if (sl_mode == 2) begin
        sl_pull = 1'b1; sl_last = sl_sh; ->sl_byte_ev;
      end else sl_pull = 1'b0;
    end else if (sl_cnt == 9) begin
      sl_cnt = 0; sl_pull = 1'b0;
      if (sl_mode == 1) sl_mode = sl_rw ? 3 : 2;
      else if (sl_mode == 3 && sl_mnak) sl_mode = 0;
      if (sl_mode == 3) begin
        sl_cur = rd_mem[sl_idx]; sl_idx = (sl_idx + 1) % 3; sl_pull = ~sl_cur[7];
      end
    end else if (sl_mode == 3) sl_pull = ~sl_cur[7 - sl_cnt];
  end

  // ---- scoreboard: driver pushes, monitor pops on each byte the target collects ----
  logic [7:0] exp_q [$];
  initial forever begin
    @(sl_byte_ev);
    if (exp_q.size() == 0) check("R4 unexpected byte on bus", int'(sl_last), -1);
    else check("R4 byte seen by target", int'(sl_last), int'(exp_q.pop_front()));
  end

  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    wr(A_DAT, b);
  endtask

  // ---- clock-line timing monitor ----
  time rise_t = 0, prev_rise_t = 0, fall_t = 0;
  always @(posedge scl_line) begin prev_rise_t = rise_t; rise_t = $time; end
  always @(negedge scl_line) fall_t = $time;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    start_cnt = 0; stop_cnt = 0;

    // R1 reset state and storage registers
    rd(A_CTL, v); check("R1 control reset", v, 8'h00);
    rd(A_STA, v); check("R1 status reset", v, 8'h80);
    rd(A_DIV, v); check("R1 divider reset", v, 8'h00);
    rd(A_DAT, v); check("R1 data reset", v, 8'h00);
    check("R1 lines released", {scl_oe, sda_oe, irq}, 3'b000);
    wr(A_OWN, 8'h5A); wr(A_FLT, 8'h33);
    rd(A_OWN, v); check("R1 own address storage", v, 8'h5A);
    rd(A_FLT, v); check("R1 filter storage", v, 8'h33);

    // R3 START
    wr(A_DIV, 8'd1);
    wr(A_CTL, 8'hC0);
    wr(A_CTL, 8'hF0);
    poll(8'h20, 8'h20, "R3 bus busy after START");
    rd(A_STA, v); check("R3 no pending after START", v[1], 0);
    check("R3 START seen", start_cnt, 1);

    // R4 address byte, write direction
    wr(A_DAT, {SL_ADDR, 1'b0});
    rd(A_STA, v); check("R4 in-flight bit clear", v[7], 0);
    poll(8'h02, 8'h02, "R4 pending after byte");
    rd(A_STA, v); check("R4 done bit and ack", {v[7], v[0]}, 2'b10);
    check("R9 irq with enable", irq, 1);
    check("R2 high time div=1", int'(fall_t - rise_t), 32);
    check("R2 period div=1", int'(rise_t - prev_rise_t), 64);

    // R9 pending clear semantics
    wr(A_STA, 8'hFF); rd(A_STA, v); check("R9 write 1 keeps pending", v[1], 1);
    wr(A_STA, 8'h00); rd(A_STA, v); check("R9 write 0 clears pending", v[1], 0);
    check("R9 irq follows pending", irq, 0);

    send_byte(8'h3C);
    poll(8'h02, 8'h02, "R4 pending after data byte");
    rd(A_STA, v); check("R4 data byte acknowledged", v[0], 0);
    wr(A_STA, 8'h00);

    // R8 repeated START
    wr(A_CTL, 8'hF4);
    repeat (30) @(negedge clk);
    check("R8 repeated START seen", start_cnt, 2);
    rd(A_CTL, v); check("R8 repeat bit reads 0", v, 8'hF0);
    rd(A_STA, v); check("R8 busy kept", v[5], 1);

    // R5 / R6 pipelined receive
    wr(A_DAT, {SL_ADDR, 1'b1});
    poll(8'h02, 8'h02, "R5 address for read done");
    rd(A_STA, v); check("R5 read address acknowledged", v[0], 0);
    wr(A_STA, 8'h00);
    wr(A_CTL, 8'hE0);
    rd(A_DAT, v);                       // priming read, launches byte 0
    poll(8'h02, 8'h02, "R5 first receive done"); wr(A_STA, 8'h00);
    rd(A_DAT, v); check("R5 read returns byte 0", v, 8'hC3);
    poll(8'h02, 8'h02, "R5 second receive done"); wr(A_STA, 8'h00);
    wr(A_CTL, 8'hE8);
    rd(A_DAT, v); check("R5 read returns byte 1", v, 8'h5E);
    poll(8'h02, 8'h02, "R5 third receive done"); wr(A_STA, 8'h00);
    check("R6 ack count", ack_log.size(), 3);
    if (ack_log.size() == 3) begin
      check("R6 ACK on byte 0", ack_log[0], 0);
      check("R6 ACK on byte 1", ack_log[1], 0);
      check("R6 NACK on last byte", ack_log[2], 1);
    end

    // R7 STOP
    wr(A_CTL, 8'hC0);
    poll(8'h20, 8'h00, "R7 busy clears after STOP");
    rd(A_STA, v); check("R7 no pending after STOP", v[1], 0);
    check("R7 STOP seen", stop_cnt, 1);
    rd(A_DAT, v); check("R5 last byte, no launch when not master", v, 8'h96);
    repeat (40) @(negedge clk);
    check("R5 no bus activity after read", {start_cnt, stop_cnt}, {32'd2, 32'd1});
    check("R11 no stray high-clock data edges", start_cnt + stop_cnt, 3);
    check("R4 scoreboard drained", exp_q.size(), 0);

    // R2 at another divider, R4 not-acknowledged
    wr(A_DIV, 8'd2);
    wr(A_CTL, 8'hF0);
    poll(8'h20, 8'h20, "R3 busy for second transfer");
    wr(A_DAT, {7'h11, 1'b0});
    poll(8'h02, 8'h02, "R4 pending on unknown address");
    rd(A_STA, v); check("R4 rxak set on no-ack", v[0], 1);
    check("R2 high time div=2", int'(fall_t - rise_t), 48);
    check("R2 period div=2", int'(rise_t - prev_rise_t), 96);

    // R10 disable
    wr(A_CTL, 8'h00);
    @(negedge clk);
    check("R10 lines released", {scl_oe, sda_oe}, 2'b00);
    rd(A_STA, v); check("R10 flags cleared, busy kept", v, 8'hA0);
    check("R10 irq low", irq, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule